// File: doc/BRIEF.md
# Two-Stage GPU Reset Sequencer

This block owns the two active-low reset lines of a graphics subsystem: one for the GPU clock generator and one for the GPU core. Software talks to it through one 32-bit control word on a small valid/ready register port. A single write either puts the subsystem into reset or starts a release. The release order runs entirely in hardware.

A release request always starts by pulling both lines back into reset. It then frees the clock generator. A counter in the GPU clock domain measures a minimum gap before the core is freed. The start and finish of that gap cross between the register clock and the GPU clock through toggle handshakes and multi-flop synchronisers. A busy flag in the readback word covers a running sequence. A reset request aborts a release that is still in flight.

Top module: `gpu_rst_seq`

## Requirements
- R1: The control word sits at offset `CTRL_OFFSET` (default 0). A read of it returns the busy flag in bit 31, the three control bits in bits [2:0], and zero in bits [30:3]. A read of any other offset returns 0, and a write to any other offset has no effect.
- R2: Control bit 0 is the core release and bit 1 is the clock generator release; a 1 means released. `gpu_core_rst_no` follows bit 0 and `gpu_clkgen_rst_no` follows bit 1. Bit 2 is a spare flag with no output.
- R3: After system reset both reset outputs are low, the control word reads 0 and busy is low.
- R4: A write at the control offset whose bits [2:0] are all zero is a reset request. Bits [31:3] of the write are ignored. It clears all three control bits, so both outputs are low on the cycle after the write. This holds in every state and aborts any release in progress; the core is not released by that sequence.
- R5: A write at the control offset with nonzero bits [2:0], accepted while busy is low, is a release request. It first forces all control bits to 0, which puts both outputs low even when they were released. It then releases the clock generator and, after that, the core.
- R6: Between the clock generator release and the core release, the GPU clock has at least `GAP_CYCLES` rising edges (default 32).
- R7: Busy reads high from the accepted release request until the core is released. After an abort it stays high until the GPU-side gap count has drained. A release request made while busy is high is ignored.
- R8: When a release completes, the word reads back with bits [1:0] = 3 and bit 2 equal to bit 2 of the accepted request.
- R9: A read accepted on a clock edge gives `rd_valid_o` high with its data for exactly the following cycle. `req_ready_o` is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register-side clock |
| rst_ni | input | 1 | Active-low asynchronous system reset for both domains |
| gpu_clk_i | input | 1 | GPU-domain clock that times the release gap |
| req_valid_i | input | 1 | Register access request |
| req_ready_o | output | 1 | Access accepted (always high) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte offset of the access |
| req_wdata_i | input | 32 | Write data |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 32 | Read data |
| gpu_clkgen_rst_no | output | 1 | Clock generator reset, active low |
| gpu_core_rst_no | output | 1 | GPU core reset, active low |
| busy_o | output | 1 | Sequence in progress (same as readback bit 31) |

## Verification
The bench uses the default parameters: a gap of 32 GPU cycles, two synchroniser stages and a 4-bit offset. The GPU clock runs at about 2.6 times the register clock, and its edges never coincide with register edges. Because of that speed ratio, the whole gap window spans only a few register cycles. An abort can therefore land while the GPU-side count is still running, which exercises the drain behaviour of busy. The bench counts GPU edges between the two releases, so a shortened gap shows up directly.

// File: rtl/gpu_rst_pkg.sv
package gpu_rst_pkg;

   localparam int unsigned DATA_W    = 32;
   localparam int unsigned CTRL_W    = 3;
   localparam int unsigned BUSY_POS  = DATA_W - 1;

   // Control word, bit order fixed: [2] spare, [1] clock generator, [0] core.
   typedef struct packed {
      logic spare;
      logic cg;
      logic core;
   } ctrl_t;

   typedef enum logic [1:0] {
      SEQ_IDLE     = 2'd0,
      SEQ_OPEN_CG  = 2'd1,
      SEQ_WAIT_GAP = 2'd2
   } seq_state_e;

endpackage

// File: rtl/gpu_rst_sync.sv
module gpu_rst_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpu_rst_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[s] <= 1'b0;
            else         chain_q[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[s] <= 1'b0;
            else         chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/gpu_rst_bus.sv
module gpu_rst_bus
   import gpu_rst_pkg::*;
#(
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned CTRL_OFFSET = 0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              req_valid_i,
   output logic              req_ready_o,
   input  logic              req_write_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [DATA_W-1:0] req_wdata_i,
   output logic              rd_valid_o,
   output logic [DATA_W-1:0] rd_data_o,
   input  ctrl_t             ctrl_i,
   input  logic              busy_i,
   output logic              wr_assert_o,
   output logic              wr_deassert_o,
   output logic              wr_spare_o
);

   localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(CTRL_OFFSET);
   localparam int unsigned       PAD_W = DATA_W - CTRL_W - 1;

   if (CTRL_OFFSET >= (1 << ADDR_W)) begin : g_bad_offset
      $error("gpu_rst_bus: CTRL_OFFSET does not fit in ADDR_W bits");
   end

   logic              hit;
   logic [CTRL_W-1:0] cmd;
   logic [DATA_W-1:0] word;
   logic              unused_wdata;

   assign req_ready_o   = 1'b1;
   assign hit           = req_valid_i && (req_addr_i == OFFS);
   assign cmd           = req_wdata_i[CTRL_W-1:0];
   assign unused_wdata  = ^req_wdata_i[DATA_W-1:CTRL_W];

   // Command decode: all-zero low field means reset, anything else release.
   assign wr_assert_o   = hit && req_write_i && (cmd == '0);
   assign wr_deassert_o = hit && req_write_i && (cmd != '0);
   assign wr_spare_o    = cmd[CTRL_W-1];

   assign word = {busy_i, {PAD_W{1'b0}}, ctrl_i};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rd_valid_o <= 1'b0;
         rd_data_o  <= '0;
      end else begin
         rd_valid_o <= req_valid_i && !req_write_i;
         if (req_valid_i && !req_write_i) begin
            rd_data_o <= hit ? word : '0;
         end
      end
   end

endmodule

// File: rtl/gpu_rst_seq_fsm.sv
module gpu_rst_seq_fsm
   import gpu_rst_pkg::*;
(
   input  logic  clk_i,
   input  logic  rst_ni,
   input  logic  wr_assert_i,
   input  logic  wr_deassert_i,
   input  logic  wr_spare_i,
   input  logic  ack_tgl_i,
   output ctrl_t ctrl_o,
   output logic  req_tgl_o,
   output logic  busy_o
);

   seq_state_e state_q;
   ctrl_t      ctrl_q;
   logic       spare_q;
   logic       req_tgl_q;
   logic       pending;

   // A gap count is outstanding whenever the two toggles disagree.
   assign pending = req_tgl_q ^ ack_tgl_i;
   assign busy_o  = (state_q != SEQ_IDLE) || pending;
   assign ctrl_o  = ctrl_q;
   assign req_tgl_o = req_tgl_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q   <= SEQ_IDLE;
         ctrl_q    <= '0;
         spare_q   <= 1'b0;
         req_tgl_q <= 1'b0;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               if (wr_assert_i) begin
                  ctrl_q <= '0;
               end else if (wr_deassert_i && !pending) begin
                  // Force a clean starting point before any release.
                  ctrl_q  <= '0;
                  spare_q <= wr_spare_i;
                  state_q <= SEQ_OPEN_CG;
               end
            end
            SEQ_OPEN_CG: begin
               if (wr_assert_i) begin
                  ctrl_q  <= '0;
                  state_q <= SEQ_IDLE;
               end else begin
                  ctrl_q.cg <= 1'b1;
                  req_tgl_q <= ~req_tgl_q;
                  state_q   <= SEQ_WAIT_GAP;
               end
            end
            SEQ_WAIT_GAP: begin
               if (wr_assert_i) begin
                  ctrl_q  <= '0;
                  state_q <= SEQ_IDLE;
               end else if (!pending) begin
                  ctrl_q.core  <= 1'b1;
                  ctrl_q.spare <= spare_q;
                  state_q      <= SEQ_IDLE;
               end
            end
            default: begin
               ctrl_q  <= '0;
               state_q <= SEQ_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/gpu_rst_gap_timer.sv
module gpu_rst_gap_timer #(
   parameter int unsigned GAP_CYCLES  = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic gpu_clk_i,
   input  logic rst_ni,
   input  logic req_tgl_i,
   output logic ack_tgl_o
);

   localparam int unsigned       CNT_W = $clog2(GAP_CYCLES + 1);
   localparam logic [CNT_W-1:0]  LAST  = CNT_W'(GAP_CYCLES - 1);

   if (GAP_CYCLES < 2) begin : g_bad_gap
      $error("gpu_rst_gap_timer: GAP_CYCLES must be at least 2");
   end

   logic             req_s;
   logic             seen_q;
   logic             run_q;
   logic             ack_q;
   logic [CNT_W-1:0] cnt_q;

   gpu_rst_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk_i  (gpu_clk_i),
      .rst_ni (rst_ni),
      .d_i    (req_tgl_i),
      .q_o    (req_s)
   );

   always_ff @(posedge gpu_clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         seen_q <= 1'b0;
         run_q  <= 1'b0;
         ack_q  <= 1'b0;
         cnt_q  <= '0;
      end else if (!run_q) begin
         if (req_s != seen_q) begin
            seen_q <= req_s;
            run_q  <= 1'b1;
            cnt_q  <= '0;
         end
      end else if (cnt_q == LAST) begin
         run_q <= 1'b0;
         ack_q <= seen_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign ack_tgl_o = ack_q;

endmodule

// File: rtl/gpu_rst_seq.sv
module gpu_rst_seq
   import gpu_rst_pkg::*;
#(
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned CTRL_OFFSET = 0,
   parameter int unsigned GAP_CYCLES  = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              gpu_clk_i,
   input  logic              req_valid_i,
   output logic              req_ready_o,
   input  logic              req_write_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [31:0]       req_wdata_i,
   output logic              rd_valid_o,
   output logic [31:0]       rd_data_o,
   output logic              gpu_clkgen_rst_no,
   output logic              gpu_core_rst_no,
   output logic              busy_o
);

   ctrl_t ctrl;
   logic  busy;
   logic  wr_assert;
   logic  wr_deassert;
   logic  wr_spare;
   logic  req_tgl;
   logic  ack_gpu;
   logic  ack_reg;

   gpu_rst_bus #(
      .ADDR_W      (ADDR_W),
      .CTRL_OFFSET (CTRL_OFFSET)
   ) u_bus (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .req_valid_i   (req_valid_i),
      .req_ready_o   (req_ready_o),
      .req_write_i   (req_write_i),
      .req_addr_i    (req_addr_i),
      .req_wdata_i   (req_wdata_i),
      .rd_valid_o    (rd_valid_o),
      .rd_data_o     (rd_data_o),
      .ctrl_i        (ctrl),
      .busy_i        (busy),
      .wr_assert_o   (wr_assert),
      .wr_deassert_o (wr_deassert),
      .wr_spare_o    (wr_spare)
   );

   gpu_rst_seq_fsm u_fsm (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .wr_assert_i   (wr_assert),
      .wr_deassert_i (wr_deassert),
      .wr_spare_i    (wr_spare),
      .ack_tgl_i     (ack_reg),
      .ctrl_o        (ctrl),
      .req_tgl_o     (req_tgl),
      .busy_o        (busy)
   );

   gpu_rst_gap_timer #(
      .GAP_CYCLES  (GAP_CYCLES),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_gap (
      .gpu_clk_i (gpu_clk_i),
      .rst_ni    (rst_ni),
      .req_tgl_i (req_tgl),
      .ack_tgl_o (ack_gpu)
   );

   gpu_rst_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (ack_gpu),
      .q_o    (ack_reg)
   );

   assign gpu_clkgen_rst_no = ctrl.cg;
   assign gpu_core_rst_no   = ctrl.core;
   assign busy_o            = busy;

endmodule

// File: rtl/gpu_rst_seq_chk.sv
module gpu_rst_seq_chk #(
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned CTRL_OFFSET = 0,
   parameter int unsigned GAP_CYCLES  = 32
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              gpu_clk_i,
   input logic              req_valid_i,
   input logic              req_ready_o,
   input logic              req_write_i,
   input logic [ADDR_W-1:0] req_addr_i,
   input logic [31:0]       req_wdata_i,
   input logic              rd_valid_o,
   input logic [31:0]       rd_data_o,
   input logic              gpu_clkgen_rst_no,
   input logic              gpu_core_rst_no,
   input logic              busy_o
);

   localparam int unsigned      GW   = $clog2(GAP_CYCLES + 1) + 1;
   localparam logic [GW-1:0]    GMAX = '1;

   logic          unused_chk;
   logic [GW-1:0] gap_q;
   logic          core_prev_q;

   assign unused_chk = req_ready_o ^ (^req_wdata_i[31:3]);

   // GPU edges seen with the clock generator free and the core still held.
   always_ff @(posedge gpu_clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         gap_q       <= '0;
         core_prev_q <= 1'b0;
      end else begin
         core_prev_q <= gpu_core_rst_no;
         if (!gpu_clkgen_rst_no)                   gap_q <= '0;
         else if (!gpu_core_rst_no && gap_q != GMAX) gap_q <= gap_q + 1'b1;
      end
   end

   // R2 / R5: the core is never free while the clock generator is held
   a_r5_core_needs_cg: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gpu_core_rst_no |-> gpu_clkgen_rst_no);

   // R6: gap measured in GPU clocks
   a_r6_min_gap: assert property (@(posedge gpu_clk_i) disable iff (!rst_ni)
      (gpu_core_rst_no && !core_prev_q) |-> (gap_q >= GW'(GAP_CYCLES)));

   // R4: reset request takes effect on the next cycle
   a_r4_assert_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_write_i && req_addr_i == ADDR_W'(CTRL_OFFSET)
       && req_wdata_i[2:0] == 3'b000)
      |=> (!gpu_core_rst_no && !gpu_clkgen_rst_no));

   // R7: the core is only freed at the end of a busy sequence
   a_r7_core_rise_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(gpu_core_rst_no) |-> $past(busy_o));

   // R1: unused readback bits are zero
   a_r1_pad_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_valid_o |-> (rd_data_o[30:3] == 28'd0));

   // R9: read response timing
   a_r9_read_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && !req_write_i) |=> rd_valid_o);

   a_r9_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(req_valid_i && !req_write_i) |=> !rd_valid_o);

endmodule

bind gpu_rst_seq gpu_rst_seq_chk #(
   .ADDR_W      (ADDR_W),
   .CTRL_OFFSET (CTRL_OFFSET),
   .GAP_CYCLES  (GAP_CYCLES)
) u_chk (
   .clk_i             (clk_i),
   .rst_ni            (rst_ni),
   .gpu_clk_i         (gpu_clk_i),
   .req_valid_i       (req_valid_i),
   .req_ready_o       (req_ready_o),
   .req_write_i       (req_write_i),
   .req_addr_i        (req_addr_i),
   .req_wdata_i       (req_wdata_i),
   .rd_valid_o        (rd_valid_o),
   .rd_data_o         (rd_data_o),
   .gpu_clkgen_rst_no (gpu_clkgen_rst_no),
   .gpu_core_rst_no   (gpu_core_rst_no),
   .busy_o            (busy_o)
);

// File: tb/tb_gpu_rst_seq.sv
`timescale 1ns/1ps
module tb_gpu_rst_seq;

   localparam int unsigned ADDR_W = 4;
   localparam int unsigned GAP    = 32;

   logic              clk = 1'b0;
   logic              gclk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic              req_write = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [31:0]       req_wdata = '0;
   logic              rd_valid;
   logic [31:0]       rd_data;
   logic              cg_n;
   logic              core_n;
   logic              busy;

   int compared = 0;
   int mismatched = 0;
   int gap_run = 0;
   int last_gap = 0;
   int core_rises = 0;
   int cg_falls = 0;
   int order_bad = 0;

   always #4 clk = ~clk;
   always #1.55 gclk = ~gclk;

   gpu_rst_seq dut (
      .clk_i             (clk),
      .rst_ni            (rst_n),
      .gpu_clk_i         (gclk),
      .req_valid_i       (req_valid),
      .req_ready_o       (req_ready),
      .req_write_i       (req_write),
      .req_addr_i        (req_addr),
      .req_wdata_i       (req_wdata),
      .rd_valid_o        (rd_valid),
      .rd_data_o         (rd_data),
      .gpu_clkgen_rst_no (cg_n),
      .gpu_core_rst_no   (core_n),
      .busy_o            (busy)
   );

   // Monitors: GPU edges between the two releases, and release order.
   always @(posedge gclk) begin
      if (cg_n !== 1'b1)       gap_run = 0;
      else if (core_n !== 1'b1) gap_run = gap_run + 1;
   end
   always @(posedge core_n) begin
      last_gap   = gap_run;
      core_rises = core_rises + 1;
      if (cg_n !== 1'b1) order_bad = order_bad + 1;
   end
   always @(negedge cg_n) cg_falls = cg_falls + 1;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic chk_ge(input string req, input int act, input int lo);
      compared++;
      if (act < lo) begin
         mismatched++;
         $display("FAIL %s: actual %0d expected at least %0d", req, act, lo);
      end
   endtask

   task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic do_read(input logic [ADDR_W-1:0] a, output logic [31:0] d, output logic v);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      d = rd_data; v = rd_valid;
   endtask

   task automatic wait_idle(output logic [31:0] d);
      logic v;
      d = 32'hFFFF_FFFF;
      for (int i = 0; i < 2000; i++) begin
         do_read('0, d, v);
         if (d[31] == 1'b0) break;
      end
   endtask

   task automatic t_reset();
      logic [31:0] d; logic v;
      chk("R3 clkgen out after reset", {31'd0, cg_n}, 32'd0);
      chk("R3 core out after reset", {31'd0, core_n}, 32'd0);
      do_read('0, d, v);
      chk("R3 readback after reset", d, 32'd0);
      chk("R9 read valid", {31'd0, v}, 32'd1);
      chk("R9 ready high", {31'd0, req_ready}, 32'd1);
   endtask

   task automatic t_release();
      logic [31:0] d;
      int rises0 = core_rises;
      do_write('0, 32'h0000_0001);
      wait_idle(d);
      chk("R8 readback after release", d, 32'h0000_0003);
      chk("R2 both outputs released", {30'd0, cg_n, core_n}, 32'd3);
      chk("R5 one core release", core_rises - rises0, 1);
      chk("R5 clkgen before core", order_bad, 0);
      chk_ge("R6 gpu edges between releases", last_gap, GAP);
   endtask

   task automatic t_rerelease();
      logic [31:0] d;
      int falls0 = cg_falls;
      do_write('0, 32'h0000_0006);
      wait_idle(d);
      chk("R5 forced clear before re-release", cg_falls - falls0, 1);
      chk("R8 spare bit kept", d, 32'h0000_0007);
      chk_ge("R6 gap on re-release", last_gap, GAP);
   endtask

   task automatic t_assert();
      logic [31:0] d; logic v;
      do_write('0, 32'h0000_0000);
      chk("R4 both outputs low", {30'd0, cg_n, core_n}, 32'd0);
      do_read('0, d, v);
      chk("R4 readback cleared", d, 32'd0);
   endtask

   task automatic t_abort();
      logic [31:0] d;
      int rises0 = core_rises;
      do_write('0, 32'h0000_0001);
      for (int i = 0; i < 20 && cg_n !== 1'b1; i++) @(negedge clk);
      chk("R5 clkgen released first", {31'd0, cg_n}, 32'd1);
      chk("R5 core still held", {31'd0, core_n}, 32'd0);
      do_write('0, 32'hFFFF_FFF8);
      chk("R4 abort returns outputs to reset", {30'd0, cg_n, core_n}, 32'd0);
      wait_idle(d);
      chk("R7 busy drains, word cleared", d, 32'd0);
      repeat (60) @(negedge clk);
      chk("R4 aborted core never released", core_rises - rises0, 0);
   endtask

   task automatic t_busy_refuse();
      logic [31:0] d; logic v;
      int rises0 = core_rises;
      do_write('0, 32'h0000_0001);
      do_read('0, d, v);
      chk("R7 busy during sequence", {31'd0, d[31]}, 32'd1);
      do_write('0, 32'h0000_0004);
      wait_idle(d);
      chk("R7 request while busy ignored", d, 32'h0000_0003);
      chk("R7 single core release", core_rises - rises0, 1);
   endtask

   task automatic t_other_addr();
      logic [31:0] d; logic v;
      do_write(4'h4, 32'h0000_0000);
      chk("R1 write elsewhere ignored", {30'd0, cg_n, core_n}, 32'd3);
      do_read(4'h4, d, v);
      chk("R1 read elsewhere is zero", d, 32'd0);
      do_read('0, d, v);
      chk("R1 word unchanged", d, 32'h0000_0003);
   endtask

   task automatic t_mask();
      logic [31:0] d;
      do_write('0, 32'h0000_0000);
      do_write('0, 32'hFFFF_FFFC);
      wait_idle(d);
      chk("R1 upper write bits masked", d, 32'h0000_0007);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_release();
      t_rerelease();
      t_assert();
      t_abort();
      t_busy_refuse();
      t_other_addr();
      t_mask();
      repeat (5) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      #1_000_000;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule